// File: doc/BRIEF.md
# Page Write Buffer with In-Page Wraparound

This block gathers the data bytes of one write burst into a page-sized staging buffer and then writes them into a byte-wide storage array. A burst opens with a start strobe that carries the target address. The upper address bits select the page and stay fixed for the whole burst. The lower bits give the first byte position. Each byte strobe stores one byte and moves the position forward by one. The position wraps inside the page, so a burst longer than a page overwrites bytes loaded earlier.

The burst-end strobe marks the rising edge of the chip select. When at least one byte has been loaded, this strobe starts a timed program cycle. During that cycle a scanner walks the page positions in ascending order and issues one array write per loaded byte. A busy flag stays high for a fixed, parameterised number of clocks. On the final busy clock a one-cycle pulse tells the command logic to drop its write-enable latch. Load, start and burst-end strobes that arrive while busy are discarded.

Top module: `page_wr_buffer`

## Requirements
- R1: After reset, busy, mem_we and wel_clear are all 0.
- R2: A start strobe takes the page from ld_addr[ADDR_W-1:4] and the first byte position from ld_addr[3:0] (with PAGE_BYTES = 16). Every array write of that burst carries the same page bits.
- R3: After position 15 the next byte goes to position 0 of the same page. When a position is loaded twice, the byte loaded last is the one written.
- R4: Only positions that were loaded are written. Writes come in ascending position order. The write for position p appears p+1 clocks after the clock edge that sampled the burst-end strobe.
- R5: Loaded bytes are never written to the array before a burst-end strobe arrives.
- R6: A burst-end strobe arriving while no byte is loaded starts no cycle: busy stays 0 and no write appears.
- R7: busy rises on the clock edge that samples the burst-end strobe and stays high for exactly CYCLE_CLKS clocks.
- R8: wel_clear is high for exactly one clock per program cycle, on the last clock that busy is high.
- R9: While busy, ld_start, ld_valid and burst_end have no effect. The loaded-byte record is cleared when the cycle ends, so a later burst-end strobe with no new loads starts nothing.
- R10: A byte strobe in the same clock as the burst-end strobe is included in the commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ld_start | input | 1 | Opens a burst and captures ld_addr |
| ld_addr | input | ADDR_W | Start address: page in the upper bits, byte position in the lower bits |
| ld_valid | input | 1 | A data byte is present on ld_data |
| ld_data | input | 8 | Data byte |
| burst_end | input | 1 | End of burst (chip-select rising edge) |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Program cycle in progress |
| wel_clear | output | 1 | One-clock pulse on the last busy clock |

## Verification
Two of the block's functions can fall in the same clock:
- **Last byte and burst end.** The bench raises ld_valid in the same clock as burst_end. The commit must then include that byte at its proper page position, with the write landing in the scheduled clock.
- **Loading and programming.** The bench drives start, byte and burst-end strobes while busy is high. It then issues a bare burst-end strobe after the cycle. The scoreboard must see no further write, and busy must not rise again; this shows that nothing leaked into the staging buffer.

The scoreboard records the clock of every expected write, so it also checks the write schedule and the wrap overwrite order.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_BUSY = 1'b1
  } pwb_phase_e;
endpackage

// File: rtl/pwb_loader.sv
module pwb_loader #(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned PAGE_BYTES = 16,
  localparam int unsigned OFS_W     = $clog2(PAGE_BYTES),
  localparam int unsigned PG_W      = ADDR_W - OFS_W
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       accept,
  input  logic                                       start,
  input  logic [ADDR_W-1:0]                          start_addr,
  input  logic                                       valid,
  input  logic [pwb_pkg::BYTE_W-1:0]                 data,
  input  logic                                       clear,
  output logic [PG_W-1:0]                            page_o,
  output logic [PAGE_BYTES-1:0]                      mask_o,
  output logic [PAGE_BYTES-1:0][pwb_pkg::BYTE_W-1:0] bytes_o
);
  logic [PG_W-1:0]       page_q, page_d;
  logic [OFS_W-1:0]      ofs_q, ofs_d;
  logic [PAGE_BYTES-1:0] mask_q, mask_d;
  logic [PAGE_BYTES-1:0][pwb_pkg::BYTE_W-1:0] buf_q;
  logic take_start, take_byte;

  assign take_start = accept & start;
  assign take_byte  = accept & valid & ~start;

  always_comb begin
    page_d = page_q;
    ofs_d  = ofs_q;
    mask_d = mask_q;
    if (clear) mask_d = '0;
    if (take_start) begin
      page_d = start_addr[ADDR_W-1:OFS_W];
      ofs_d  = start_addr[OFS_W-1:0];
      mask_d = '0;
    end else if (take_byte) begin
      mask_d[ofs_q] = 1'b1;
      ofs_d         = ofs_q + 1'b1;   // position wraps inside the page
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      ofs_q  <= '0;
      mask_q <= '0;
    end else begin
      page_q <= page_d;
      ofs_q  <= ofs_d;
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take_byte) buf_q[ofs_q] <= data;
  end

  assign page_o  = page_q;
  assign mask_o  = mask_q;
  assign bytes_o = buf_q;

  // R3: loading past the last position continues at position 0
  p_ofs_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_byte && ofs_q == OFS_W'(PAGE_BYTES-1)) |=> (ofs_q == '0));

  // R9: while not accepting, the staged page and record stay frozen
  p_frozen_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !clear) |=> ($stable(mask_q) && $stable(page_q)));
endmodule

// File: rtl/pwb_drain.sv
module pwb_drain #(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned PAGE_BYTES = 16,
  localparam int unsigned OFS_W     = $clog2(PAGE_BYTES),
  localparam int unsigned PG_W      = ADDR_W - OFS_W
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       go,
  input  logic                                       busy_i,
  input  logic [PG_W-1:0]                            page,
  input  logic [PAGE_BYTES-1:0]                      mask,
  input  logic [PAGE_BYTES-1:0][pwb_pkg::BYTE_W-1:0] bytes,
  output logic                                       we,
  output logic [ADDR_W-1:0]                          waddr,
  output logic [pwb_pkg::BYTE_W-1:0]                 wdata
);
  logic             act_q, act_d;
  logic [OFS_W-1:0] idx_q, idx_d;

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    if (go) begin
      act_d = 1'b1;
      idx_d = '0;
    end else if (act_q) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == OFS_W'(PAGE_BYTES-1)) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
    end
  end

  assign we    = act_q & mask[idx_q];
  assign waddr = {page, idx_q};
  assign wdata = bytes[idx_q];

  // R4: array writes only happen inside the timed program cycle
  p_write_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> busy_i);
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int unsigned CYCLE_CLKS = 40,
  localparam int unsigned CNT_W     = $clog2(CYCLE_CLKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy,
  output logic last
);
  import pwb_pkg::*;

  pwb_phase_e       ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (ph_q == PH_IDLE) begin
      if (go) begin
        ph_d  = PH_BUSY;
        cnt_d = CNT_W'(CYCLE_CLKS - 1);
      end
    end else if (cnt_q == '0) begin
      ph_d = PH_IDLE;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy = (ph_q == PH_BUSY);
  assign last = busy & (cnt_q == '0);

  // R7: busy cannot drop before the count is spent
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);

  // R8: the end pulse is followed by idle
  p_last_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (!busy && !last));
endmodule

// File: rtl/page_wr_buffer.sv
module page_wr_buffer #(
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned CYCLE_CLKS = 40,   // must exceed PAGE_BYTES
  localparam int unsigned OFS_W     = $clog2(PAGE_BYTES),
  localparam int unsigned PG_W      = ADDR_W - OFS_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_start,
  input  logic [ADDR_W-1:0]          ld_addr,
  input  logic                       ld_valid,
  input  logic [pwb_pkg::BYTE_W-1:0] ld_data,
  input  logic                       burst_end,
  output logic                       mem_we,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [pwb_pkg::BYTE_W-1:0] mem_wdata,
  output logic                       busy,
  output logic                       wel_clear
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic                                       go, last;
  logic [PG_W-1:0]                            page;
  logic [PAGE_BYTES-1:0]                      mask;
  logic [PAGE_BYTES-1:0][pwb_pkg::BYTE_W-1:0] bytes;
  logic                                       has_bytes;

  assign has_bytes = |mask;
  assign go = burst_end & ~busy & ~ld_start & (has_bytes | ld_valid);

  pwb_loader #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_loader (
    .clk(clk), .rst_n(rst_sync_q), .accept(~busy), .start(ld_start),
    .start_addr(ld_addr), .valid(ld_valid), .data(ld_data), .clear(last),
    .page_o(page), .mask_o(mask), .bytes_o(bytes)
  );

  pwb_drain #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_drain (
    .clk(clk), .rst_n(rst_sync_q), .go(go), .busy_i(busy), .page(page),
    .mask(mask), .bytes(bytes), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata)
  );

  pwb_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_sync_q), .go(go), .busy(busy), .last(last)
  );

  assign wel_clear = last;

  // R6: an end strobe with nothing loaded leaves the block idle
  p_no_empty_commit_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (burst_end && !busy && !has_bytes && !ld_valid) |=> !busy);

  // R5: a program cycle only ever follows an end strobe
  p_commit_needs_end_r5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(busy) |-> $past(burst_end));
endmodule

// File: tb/page_wr_buffer_test.sv
module page_wr_buffer_test;
  localparam int unsigned AW  = 9;
  localparam int unsigned PB  = 16;
  localparam int unsigned CYC = 40;

  typedef struct packed {
    logic [31:0]   t;
    logic [AW-1:0] a;
    logic [7:0]    d;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic ld_start, ld_valid, burst_end;
  logic [AW-1:0] ld_addr;
  logic [7:0] ld_data;
  logic mem_we, busy, wel_clear;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;

  always #4 clk = ~clk;

  page_wr_buffer #(.ADDR_W(AW), .PAGE_BYTES(PB), .CYCLE_CLKS(CYC)) uut (
    .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_addr(ld_addr),
    .ld_valid(ld_valid), .ld_data(ld_data), .burst_end(burst_end),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .wel_clear(wel_clear)
  );

  int total = 0;
  int bad   = 0;
  int tick  = 0;
  bit running = 0;
  bit finished = 0;
  exp_t exp_q[$];

  // Reference page model
  logic [AW-5:0]      m_page;
  logic [3:0]         m_ofs;
  logic [PB-1:0]      m_mask;
  logic [PB-1:0][7:0] m_buf;

  always @(posedge clk) tick <= tick + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Monitor: scoreboard and busy-run checks
  int  run_len = 0;
  int  clr_cnt = 0;
  bit  prev_clr = 0;
  always @(negedge clk) begin
    if (running) begin
      if (mem_we) begin
        if (exp_q.size() == 0) begin
          check(0, "R5", "unexpected write addr", int'(mem_addr), 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(tick == int'(e.t), "R4", "write clock", tick, int'(e.t));
          check(mem_addr == e.a, "R2", "write address", int'(mem_addr), int'(e.a));
          check(mem_wdata == e.d, "R3", "write data", int'(mem_wdata), int'(e.d));
        end
      end
      if (prev_clr) check(!busy, "R8", "busy after clear pulse", int'(busy), 0);
      prev_clr = wel_clear;
      if (busy) begin
        run_len++;
        if (wel_clear) clr_cnt++;
      end else if (run_len != 0) begin
        check(run_len == CYC, "R7", "busy length", run_len, CYC);
        check(clr_cnt == 1, "R8", "clear pulses", clr_cnt, 1);
        check(exp_q.size() == 0, "R4", "writes left over", exp_q.size(), 0);
        run_len = 0;
        clr_cnt = 0;
      end
    end
  end

  task automatic idle_inputs();
    ld_start = 0; ld_valid = 0; burst_end = 0; ld_addr = '0; ld_data = '0;
  endtask

  task automatic drv_start(input logic [AW-1:0] a);
    @(negedge clk); ld_start = 1; ld_addr = a;
    @(negedge clk); ld_start = 0;
  endtask

  task automatic drv_byte(input logic [7:0] d);
    @(negedge clk); ld_valid = 1; ld_data = d;
    @(negedge clk); ld_valid = 0;
  endtask

  task automatic start_burst(input logic [AW-1:0] a);
    m_page = a[AW-1:4]; m_ofs = a[3:0]; m_mask = '0;
    drv_start(a);
  endtask

  task automatic put_byte(input logic [7:0] d);
    m_buf[m_ofs] = d; m_mask[m_ofs] = 1'b1; m_ofs = m_ofs + 1'b1;
    drv_byte(d);
  endtask

  task automatic end_burst(input bit with_byte, input logic [7:0] d);
    int et;
    bit commit;
    @(negedge clk);
    burst_end = 1;
    if (with_byte) begin
      ld_valid = 1; ld_data = d;
      m_buf[m_ofs] = d; m_mask[m_ofs] = 1'b1; m_ofs = m_ofs + 1'b1;
    end
    et = tick;
    commit = (m_mask != '0);
    if (commit)
      for (int o = 0; o < int'(PB); o++)
        if (m_mask[o]) exp_q.push_back({32'(et + 1 + o), {m_page, 4'(o)}, m_buf[o]});
    @(negedge clk);
    burst_end = 0; ld_valid = 0;
    check(busy == commit, commit ? "R7" : "R6", "busy after end", int'(busy), int'(commit));
    m_mask = '0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    m_mask = '0; m_buf = '0; m_page = '0; m_ofs = '0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !mem_we && !wel_clear, "R1", "reset outputs",
          {busy, mem_we, wel_clear}, 0);
    running = 1;

    // R2: short burst mid-page
    start_burst(9'h123);
    put_byte(8'hA1); put_byte(8'hB2); put_byte(8'hC3);
    end_burst(0, 8'h00);

    // R3: 20 bytes from position 14 wrap and overwrite positions 0 and 1
    start_burst(9'h05E);
    for (int i = 0; i < 20; i++) put_byte(8'(8'h40 + i));
    end_burst(0, 8'h00);

    // R6: burst with no data byte
    start_burst(9'h040);
    end_burst(0, 8'h00);
    repeat (20) @(negedge clk);
    check(!busy, "R6", "busy after empty burst", int'(busy), 0);

    // R5: loaded bytes stay unwritten until the end strobe
    start_burst(9'h1F0);
    put_byte(8'h11); put_byte(8'h22);
    repeat (30) @(negedge clk);
    check(!busy && !mem_we, "R5", "activity before end", {busy, mem_we}, 0);
    end_burst(0, 8'h00);

    // R10: byte in the same clock as the end strobe
    start_burst(9'h0A7);
    put_byte(8'h5A);
    end_burst(1, 8'hC9);

    // R9: strobes during busy are ignored, record cleared at cycle end
    start_burst(9'h1C2);
    put_byte(8'h77);
    @(negedge clk);
    burst_end = 1;
    exp_q.push_back({32'(tick + 1 + 2), 9'h1C2, 8'h77});
    @(negedge clk);
    burst_end = 0;
    m_mask = '0;
    check(busy, "R7", "busy after end", int'(busy), 1);
    drv_start(9'h100);
    drv_byte(8'hEE); drv_byte(8'hEF);
    @(negedge clk); burst_end = 1;
    @(negedge clk); burst_end = 0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    @(negedge clk); burst_end = 1;
    @(negedge clk); burst_end = 0;
    check(!busy, "R9", "cycle from ignored loads", int'(busy), 0);
    repeat (25) @(negedge clk);
    check(!busy && exp_q.size() == 0, "R9", "late activity", int'(busy), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule